// File: doc/BRIEF.md
# Receive Endpoint Packet Buffer

This block holds one packet for a single host-to-device endpoint. A USB-side engine streams the received bytes in one at a time and, when the packet has been acknowledged, pulses a commit strobe. The commit records how many bytes arrived and marks the buffer as occupied. While it is occupied the USB side sees a full flag, and its byte input is refused, which stands in for a NAK.

The local processor drains the packet through a 16-bit read port. The port is a valid/ready stream. After a commit, the valid output stays low for a fixed settling time. From then on, each accepted read delivers two bytes and the remaining count drops by two. Valid stays asserted with the same data until ready is seen high, and the consumer may hold ready low for as long as it likes. An odd-length packet ends with a read that carries the last byte in the low lane and zero in the high lane.

Once every byte has been read, the buffer empties itself and accepts a new packet. Software can discard a packet at any point with a flush strobe. A bus reset empties the buffer and zeroes the recorded byte count.

Top module: `rxbuf_endpoint`

## Requirements
- R1: A byte is stored when `usb_wvalid` and `usb_wready` are both high at a clock edge. `usb_wready` is high only while the buffer is empty, fewer than MAX_BYTES bytes have been collected, and `usb_commit` is low.
- R2: A `usb_commit` pulse while the buffer is empty copies the number of bytes collected since the last commit or clear into `data_count`. If that number is nonzero, `buf_full` rises on the same edge. A zero-length commit sets `data_count` to 0 and leaves the buffer empty.
- R3: While `buf_full` is high, `usb_wready` is low and a `usb_commit` pulse is refused, leaving `data_count` unchanged.
- R4: After a commit, `cpu_rvalid` stays low for SETTLE_CYC cycles and then rises. `cpu_rvalid` is never high while the buffer is empty.
- R5: The k-th accepted read returns packet byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Each accepted read that is not the last lowers `rem_count` by 2.
- R6: For an odd-length packet, the final read returns the last byte in bits 7:0 and zero in bits 15:8. That read counts as having consumed the whole packet.
- R7: On the edge that accepts the read carrying the final byte, `buf_full` falls, `rem_count` becomes 0 and `usb_wready` returns. `data_count` keeps its value.
- R8: A `cpu_flush` pulse empties the buffer on the next edge, however much of it has been read, and discards any partly collected packet. `data_count` keeps its value.
- R9: A `bus_reset` pulse empties the buffer, discards partial input and sets `data_count` to 0. It takes priority over flush, commit and reads.
- R10: While `cpu_rvalid` is high and `cpu_rready` is low, `cpu_rvalid` stays high and `cpu_rdata` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Synchronous bus reset strobe |
| usb_wvalid | input | 1 | Received byte is present |
| usb_wdata | input | 8 | Received byte |
| usb_wready | output | 1 | Buffer will take the byte |
| usb_commit | input | 1 | Packet acknowledged, latch the count |
| buf_full | output | 1 | Buffer holds an unread packet |
| cpu_rvalid | output | 1 | Read word is available |
| cpu_rready | input | 1 | Processor takes the read word |
| cpu_rdata | output | 16 | Two packet bytes, lower-addressed byte in bits 7:0 |
| cpu_flush | input | 1 | Discard the buffer contents |
| data_count | output | 7 | Byte count latched at the last commit |
| rem_count | output | 7 | Bytes still unread |

## Verification
The hardest states to reach from the ports are interruptions in the middle of a packet. One is a flush after some words have been read but not all. Another is a commit arriving while a packet is still held. A third is a partial packet thrown away before it was committed. To reach them, the stimulus commits a packet, drains exactly one word with a single-cycle ready pulse, and only then flushes. Separately, it fires a commit while the buffer is full, and it flushes a few uncommitted bytes before sending a short packet. The scoreboard expects only the words that the requirements say must come out: the odd-length tail with its zeroed high lane, and nothing at all from the discarded data.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  typedef enum logic {
    BUF_OPEN = 1'b0,
    BUF_HELD = 1'b1
  } buf_state_e;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
  } port_word_t;
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import rxbuf_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int CW        = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_idx,
  input  logic [7:0]    wr_byte,
  input  logic [CW-1:0] rd_idx,
  input  logic [CW-1:0] rd_limit,
  output port_word_t    rd_word
);
  logic [MAX_BYTES*8-1:0] flat;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_cell
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == CW'(g)) q <= wr_byte;
    end
    assign flat[g*8 +: 8] = q;
  end

  logic [CW:0] hi_idx;
  logic        lo_ok, hi_ok;

  assign hi_idx = {1'b0, rd_idx} + (CW+1)'(1);
  assign lo_ok  = rd_idx < rd_limit;
  assign hi_ok  = hi_idx < {1'b0, rd_limit};

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (lo_ok && rd_idx == CW'(i)) rd_word.lo = flat[i*8 +: 8];
      if (hi_ok && hi_idx == (CW+1)'(i)) rd_word.hi = flat[i*8 +: 8];
    end
  end
endmodule

// File: rtl/rxbuf_fill.sv
module rxbuf_fill
  import rxbuf_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int CW        = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_reset,
  input  logic          flush,
  input  logic          wvalid,
  input  logic          commit,
  input  logic          drained,
  output logic          wready,
  output logic          wr_en,
  output logic [CW-1:0] wr_idx,
  output logic          commit_ok,
  output logic          full,
  output logic [CW-1:0] count
);
  buf_state_e    state;
  logic [CW-1:0] wcnt;

  assign wready    = (state == BUF_OPEN) && (wcnt < CW'(MAX_BYTES)) && !commit;
  assign wr_en     = wvalid && wready;
  assign wr_idx    = wcnt;
  assign commit_ok = commit && (state == BUF_OPEN) && !bus_reset && !flush;
  assign full      = (state == BUF_HELD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BUF_OPEN;
      wcnt  <= '0;
      count <= '0;
    end else if (bus_reset) begin
      state <= BUF_OPEN;
      wcnt  <= '0;
      count <= '0;
    end else if (flush) begin
      state <= BUF_OPEN;
      wcnt  <= '0;
    end else begin
      if (commit_ok) begin
        count <= wcnt;
        wcnt  <= '0;
        state <= (wcnt != '0) ? BUF_HELD : BUF_OPEN;
      end else if (wr_en) begin
        wcnt <= wcnt + 1'b1;
      end
      if (drained) state <= BUF_OPEN;
    end
  end
endmodule

// File: rtl/rxbuf_drain.sv
module rxbuf_drain #(
  parameter int MAX_BYTES  = 64,
  parameter int SETTLE_CYC = 3,
  parameter int CW         = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_reset,
  input  logic          flush,
  input  logic          full,
  input  logic          commit_ok,
  input  logic [CW-1:0] count,
  input  logic          rready,
  output logic          rvalid,
  output logic [CW-1:0] rd_idx,
  output logic [CW-1:0] remaining,
  output logic          drained
);
  logic          settled;
  logic [CW-1:0] rp;
  logic [CW:0]   next_pos;
  logic          take, last;

  if (SETTLE_CYC == 0) begin : g_nosettle
    assign settled = 1'b1;
  end else begin : g_settle
    localparam int SW = $clog2(SETTLE_CYC + 1);
    logic [SW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (bus_reset || flush) cnt <= '0;
      else if (commit_ok)          cnt <= SW'(SETTLE_CYC);
      else if (cnt != '0)          cnt <= cnt - 1'b1;
    end
    assign settled = (cnt == '0);
  end

  assign rvalid    = full && settled;
  assign take      = rvalid && rready;
  assign next_pos  = {1'b0, rp} + (CW+1)'(2);
  assign last      = next_pos >= {1'b0, count};
  assign drained   = take && last && !bus_reset && !flush;
  assign rd_idx    = rp;
  assign remaining = full ? (count - rp) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               rp <= '0;
    else if (bus_reset || flush || commit_ok) rp <= '0;
    else if (take)                            rp <= last ? '0 : next_pos[CW-1:0];
  end
endmodule

// File: rtl/rxbuf_endpoint.sv
module rxbuf_endpoint
  import rxbuf_pkg::*;
#(
  parameter int MAX_BYTES  = 64,
  parameter int SETTLE_CYC = 3,
  localparam int CW        = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_reset,
  input  logic          usb_wvalid,
  input  logic [7:0]    usb_wdata,
  output logic          usb_wready,
  input  logic          usb_commit,
  output logic          buf_full,
  output logic          cpu_rvalid,
  input  logic          cpu_rready,
  output logic [15:0]   cpu_rdata,
  input  logic          cpu_flush,
  output logic [CW-1:0] data_count,
  output logic [CW-1:0] rem_count
);
  logic          wr_en, commit_ok, drained;
  logic [CW-1:0] wr_idx, rd_idx;
  port_word_t    word;

  rxbuf_fill #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_fill (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .flush(cpu_flush),
    .wvalid(usb_wvalid), .commit(usb_commit), .drained(drained),
    .wready(usb_wready), .wr_en(wr_en), .wr_idx(wr_idx),
    .commit_ok(commit_ok), .full(buf_full), .count(data_count)
  );

  rxbuf_store #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(usb_wdata),
    .rd_idx(rd_idx), .rd_limit(data_count), .rd_word(word)
  );

  rxbuf_drain #(.MAX_BYTES(MAX_BYTES), .SETTLE_CYC(SETTLE_CYC), .CW(CW)) u_drain (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .flush(cpu_flush),
    .full(buf_full), .commit_ok(commit_ok), .count(data_count),
    .rready(cpu_rready), .rvalid(cpu_rvalid), .rd_idx(rd_idx),
    .remaining(rem_count), .drained(drained)
  );

  assign cpu_rdata = word;
endmodule

// File: rtl/rxbuf_endpoint_chk.sv
module rxbuf_endpoint_chk #(
  parameter int MAX_BYTES  = 64,
  parameter int SETTLE_CYC = 3,
  localparam int CW        = $clog2(MAX_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_reset,
  input logic          usb_wready,
  input logic          usb_commit,
  input logic          buf_full,
  input logic          cpu_rvalid,
  input logic          cpu_rready,
  input logic [15:0]   cpu_rdata,
  input logic          cpu_flush,
  input logic [CW-1:0] data_count,
  input logic [CW-1:0] rem_count
);
  logic quiet;
  assign quiet = !bus_reset && !cpu_flush;

  assert_no_write_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !usb_wready);

  assert_refused_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_commit && buf_full && quiet) |=> $stable(data_count));

  assert_valid_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> buf_full);

  if (SETTLE_CYC > 0) begin : g_gap
    assert_settle_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_full) |-> !cpu_rvalid);
  end

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rvalid && cpu_rready && rem_count > CW'(2) && quiet)
      |=> rem_count == $past(rem_count) - CW'(2));

  assert_odd_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rvalid && rem_count == CW'(1)) |-> cpu_rdata[15:8] == 8'h00);

  assert_auto_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rvalid && cpu_rready && rem_count <= CW'(2) && quiet)
      |=> (!buf_full && $stable(data_count)));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_flush && !bus_reset) |=> (!buf_full && $stable(data_count)));

  assert_bus_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!buf_full && data_count == '0));

  assert_hold_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rvalid && !cpu_rready && quiet) |=> (cpu_rvalid && $stable(cpu_rdata)));
endmodule

bind rxbuf_endpoint rxbuf_endpoint_chk #(.MAX_BYTES(MAX_BYTES), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .usb_wready(usb_wready),
  .usb_commit(usb_commit), .buf_full(buf_full), .cpu_rvalid(cpu_rvalid),
  .cpu_rready(cpu_rready), .cpu_rdata(cpu_rdata), .cpu_flush(cpu_flush),
  .data_count(data_count), .rem_count(rem_count)
);

// File: tb/rxbuf_endpoint_bench.sv
module rxbuf_endpoint_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB       = 64;
  localparam int SETTLE     = 3;
  localparam int CW         = $clog2(MAXB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_reset = 1'b0;
  logic          usb_wvalid = 1'b0;
  logic [7:0]    usb_wdata = '0;
  logic          usb_wready;
  logic          usb_commit = 1'b0;
  logic          buf_full;
  logic          cpu_rvalid;
  logic          cpu_rready = 1'b0;
  logic [15:0]   cpu_rdata;
  logic          cpu_flush = 1'b0;
  logic [CW-1:0] data_count;
  logic [CW-1:0] rem_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbuf_endpoint #(.MAX_BYTES(MAXB), .SETTLE_CYC(SETTLE)) u_rxbuf_endpoint (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .usb_wvalid(usb_wvalid), .usb_wdata(usb_wdata), .usb_wready(usb_wready),
    .usb_commit(usb_commit), .buf_full(buf_full), .cpu_rvalid(cpu_rvalid),
    .cpu_rready(cpu_rready), .cpu_rdata(cpu_rdata), .cpu_flush(cpu_flush),
    .data_count(data_count), .rem_count(rem_count)
  );

  int          n_checks = 0;
  int          n_fails  = 0;
  string       cur_req  = "R5";
  logic [15:0] exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 37 + i * 5 + 3);
  endfunction

  // monitor: a handshake seen here completes on the following rising edge
  always @(negedge clk) begin
    if (rst_n && cpu_rvalid && cpu_rready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, int'(cpu_rdata), 32'hFFFF);
      end else begin
        logic [15:0] w;
        w = exp_q.pop_front();
        check(cpu_rdata == w, cur_req, int'(cpu_rdata), int'(w));
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load(input int len, input int seed, input bit push);
    for (int i = 0; i < len; i++) begin
      usb_wvalid = 1'b1;
      usb_wdata  = pat(seed, i);
      step();
    end
    usb_wvalid = 1'b0;
    if (push) begin
      for (int k = 0; k < len; k += 2) begin
        logic [15:0] w;
        w[7:0]  = pat(seed, k);
        w[15:8] = (k + 1 < len) ? pat(seed, k + 1) : 8'h00;
        exp_q.push_back(w);
      end
    end
  endtask

  task automatic commit();
    usb_commit = 1'b1;
    step();
    usb_commit = 1'b0;
  endtask

  task automatic wait_valid();
    while (!cpu_rvalid) step();
  endtask

  task automatic drain();
    cpu_rready = 1'b1;
    while (exp_q.size() != 0) step();
    cpu_rready = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    // reset state
    check(!buf_full && usb_wready && !cpu_rvalid, "R1", {buf_full, usb_wready, cpu_rvalid}, 3'b010);
    check(data_count == 0, "R9", int'(data_count), 0);

    // even packet, settle gap, ordered words, auto release
    load(8, 1, 1'b1);
    commit();
    check(buf_full && data_count == 8, "R2", int'(data_count), 8);
    check(!usb_wready, "R3", int'(usb_wready), 0);
    for (int k = 0; k < SETTLE; k++) begin
      check(!cpu_rvalid, "R4", int'(cpu_rvalid), 0);
      step();
    end
    check(cpu_rvalid, "R4", int'(cpu_rvalid), 1);
    check(rem_count == 8, "R5", int'(rem_count), 8);
    cur_req = "R5";
    drain();
    check(!buf_full && rem_count == 0 && usb_wready, "R7", {buf_full, usb_wready}, 2'b01);
    check(data_count == 8, "R7", int'(data_count), 8);

    // odd packet with zeroed upper lane on the tail
    load(7, 2, 1'b1);
    commit();
    wait_valid();
    cur_req = "R6";
    drain();
    check(!buf_full && rem_count == 0, "R6", int'(buf_full), 0);

    // zero-length commit
    commit();
    check(data_count == 0 && !buf_full, "R2", int'(data_count), 0);

    // maximum length fill
    load(MAXB, 3, 1'b1);
    check(!usb_wready, "R1", int'(usb_wready), 0);
    commit();
    check(data_count == CW'(MAXB), "R1", int'(data_count), MAXB);
    cur_req = "R1";
    drain();

    // commit while full is refused
    load(4, 4, 1'b1);
    commit();
    usb_wvalid = 1'b1;
    usb_wdata  = 8'hEE;
    check(!usb_wready, "R3", int'(usb_wready), 0);
    step();
    usb_wvalid = 1'b0;
    commit();
    check(data_count == 4 && buf_full, "R3", int'(data_count), 4);
    wait_valid();
    cur_req = "R3";
    drain();

    // stalled consumer holds word
    load(6, 5, 1'b1);
    commit();
    wait_valid();
    begin
      logic [15:0] held;
      held = cpu_rdata;
      step();
      step();
      check(cpu_rvalid && cpu_rdata == held, "R10", int'(cpu_rdata), int'(held));
      check(held == exp_q[0], "R10", int'(held), int'(exp_q[0]));
    end
    cur_req = "R10";
    drain();

    // flush in the middle of a packet
    load(10, 6, 1'b1);
    commit();
    wait_valid();
    cur_req = "R5";
    cpu_rready = 1'b1;
    step();
    cpu_rready = 1'b0;
    check(rem_count == 8, "R5", int'(rem_count), 8);
    cpu_flush = 1'b1;
    step();
    cpu_flush = 1'b0;
    exp_q.delete();
    check(!buf_full && rem_count == 0 && !cpu_rvalid, "R8", int'(buf_full), 0);
    check(data_count == 10, "R8", int'(data_count), 10);

    // flush discards uncommitted bytes
    load(3, 7, 1'b0);
    cpu_flush = 1'b1;
    step();
    cpu_flush = 1'b0;
    load(2, 8, 1'b1);
    commit();
    check(data_count == 2, "R8", int'(data_count), 2);
    wait_valid();
    cur_req = "R8";
    drain();

    // bus reset wipes packet and count
    load(6, 9, 1'b0);
    commit();
    bus_reset = 1'b1;
    step();
    bus_reset = 1'b0;
    check(!buf_full && data_count == 0 && usb_wready, "R9", int'(data_count), 0);
    repeat (SETTLE + 2) step();
    check(!cpu_rvalid, "R9", int'(cpu_rvalid), 0);

    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule